// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Oscillator

This block synthesises a digital sinusoid for an impedance-measurement front end. A 5-bit rate code selects one of 32 fixed output frequencies, geometrically spaced from 100 Hz to about 1 MHz. An angle generator turns that code into a phase step and adds it to a 24-bit phase register once per output sample. A quadrant stage then rotates the starting vector by a multiple of 90 degrees, so the remaining angle always lies within the range where CORDIC converges. A single shift-and-add rotation stage is reused for twelve clock cycles to produce both the cosine and the sine of the phase.

A one-bit function input selects whether the sine or the cosine goes to the 10-bit offset-binary sample port, which feeds an external DAC. A one-cycle strobe marks each new sample. The sequencer has three states. LOAD captures the phase, the pre-rotated vector and the residual angle, and advances the phase register. ROTATE performs one micro-rotation per cycle and stays in ROTATE until the twelfth iteration, then moves to EMIT. EMIT hands the result to the output register and returns to LOAD. One sample therefore takes 14 clock cycles. With the default 56 MHz clock the sample rate is 4 MHz.

Top module: `cordic_nco`

## Requirements
- R1: While reset is held and after its release until the first strobe, `sample_out` is 512 (0x200, offset-binary zero) and `sample_valid` is 0.
- R2: `sample_valid` is high for exactly one cycle. It first rises in the 14th cycle after reset release and then rises every 14 cycles.
- R3: Code c selects frequency f(c), where f(0)=100 and f(c)=floor(f(c-1)*1346/1000). The phase step is round(f(c)*2^24/fs), with fs = CLK_HZ/14.
- R4: The phase register starts at 0 and wraps modulo 2^24. `freq_sel` is sampled in the first cycle after reset and in every cycle where `sample_valid` is high. The value sampled there sets the step between the phase of the sample now being loaded and the phase of the next sample.
- R5: The top two phase bits give the quadrant (00: 0°, 01: 90°, 10: 180°, 11: 270°). Samples are correct in all four quadrants.
- R6: Sample n is computed from phase p(n). In sine mode its signed value is within ±3 of round(511·sin(2π·p/2^24)). In cosine mode the same tolerance applies to 511·cos(2π·p/2^24).
- R7: `sample_out` is offset binary: the signed value plus 512, which is the signed value with its MSB inverted. It is never 0, because the signed value is clamped to ±511.
- R8: Between strobes, `sample_out` holds its value.
- R9: `func_sel` is sampled one cycle before the strobe. Value 0 selects the sine and value 1 the cosine. It may change from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 5 | Output frequency code |
| func_sel | input | 1 | 0 = sine, 1 = cosine on the sample port |
| sample_out | output | 10 | Offset-binary sample for the DAC |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The cycle that carries the strobe for one sample is also the LOAD cycle of the next sample. A new rate code or function choice therefore arrives in the same cycle that a finished result is published. The bench changes `freq_sel` and `func_sel` exactly at strobes, and in one stretch it toggles the function on every sample. A queue of expected phases checks each sample against the code that was present in the cycle of its LOAD step. This shows that the step is neither lost nor applied one sample early.

// File: rtl/nco_pkg.sv
package nco_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_ROTATE = 2'd1,
        ST_EMIT   = 2'd2
    } cordic_state_e;

    // Arctangent of 2^-idx, in units of a full turn scaled to 2^pw.
    function automatic logic [63:0] atan_turns(input int idx, input int pw);
        logic [63:0] b;
        case (idx)
            0:       b = 64'd2097152;
            1:       b = 64'd1238021;
            2:       b = 64'd654137;
            3:       b = 64'd332050;
            4:       b = 64'd166669;
            5:       b = 64'd83416;
            6:       b = 64'd41718;
            7:       b = 64'd20860;
            8:       b = 64'd10430;
            9:       b = 64'd5215;
            10:      b = 64'd2608;
            11:      b = 64'd1304;
            default: b = 64'd1304 >> (idx - 11);
        endcase
        if (pw >= 24) return b << (pw - 24);
        return b >> (24 - pw);
    endfunction

    // Phase step for a rate code: geometric frequency ladder, rounded.
    function automatic logic [63:0] phase_inc(input int code, input int pw,
                                              input longint base_hz, input longint num,
                                              input longint den, input longint fs_hz);
        longint f;
        f = base_hz;
        for (int k = 0; k < code; k++) f = (f * num) / den;
        return 64'(((f <<< pw) + fs_hz / 2) / fs_hz);
    endfunction

endpackage

// File: rtl/nco_angle_gen.sv
module nco_angle_gen #(
    parameter int     SEL_W         = 5,
    parameter int     PHASE_W       = 24,
    parameter longint CLK_HZ        = 56_000_000,
    parameter int     SAMPLE_CYCLES = 14,
    parameter longint F_BASE_HZ     = 100,
    parameter longint STEP_NUM      = 1346,
    parameter longint STEP_DEN      = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   freq_sel,
    input  logic               step,
    output logic [PHASE_W-1:0] phase
);
    localparam int     CODES = 1 << SEL_W;
    localparam longint FS_HZ = CLK_HZ / SAMPLE_CYCLES;

    logic [PHASE_W-1:0] inc_tbl [CODES];

    generate
        for (genvar c = 0; c < CODES; c++) begin : g_inc
            assign inc_tbl[c] = PHASE_W'(nco_pkg::phase_inc(c, PHASE_W, F_BASE_HZ,
                                                            STEP_NUM, STEP_DEN, FS_HZ));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (step) phase <= phase + inc_tbl[freq_sel];
    end
endmodule

// File: rtl/nco_prerotate.sv
module nco_prerotate #(
    parameter int PHASE_W = 24,
    parameter int W       = 18,
    parameter logic signed [W-1:0] X0 = 18'sd19859
) (
    input  logic [PHASE_W-1:0]        phase,
    output logic signed [W-1:0]       x_init,
    output logic signed [W-1:0]       y_init,
    output logic signed [PHASE_W-1:0] z_init
);
    always_comb begin
        z_init = {2'b00, phase[PHASE_W-3:0]};
        unique case (phase[PHASE_W-1:PHASE_W-2])
            2'b00: begin x_init = X0;  y_init = '0;  end
            2'b01: begin x_init = '0;  y_init = X0;  end
            2'b10: begin x_init = -X0; y_init = '0;  end
            default: begin x_init = '0; y_init = -X0; end
        endcase
    end
endmodule

// File: rtl/nco_cordic_core.sv
module nco_cordic_core
    import nco_pkg::*;
#(
    parameter int W       = 18,
    parameter int PHASE_W = 24,
    parameter int ITERS   = 12,
    parameter int IT_W    = $clog2(ITERS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [W-1:0]       x_init,
    input  logic signed [W-1:0]       y_init,
    input  logic signed [PHASE_W-1:0] z_init,
    output logic                      phase_step,
    output logic                      done,
    output logic signed [W-1:0]       x_res,
    output logic signed [W-1:0]       y_res,
    output logic signed [PHASE_W-1:0] z_res,
    output cordic_state_e             state,
    output logic [IT_W-1:0]           iter
);
    localparam logic [IT_W-1:0] LAST = IT_W'(ITERS - 1);

    cordic_state_e state_q, state_d;
    logic signed [W-1:0]       x_q, y_q, dx, dy;
    logic signed [PHASE_W-1:0] z_q, atan_i;
    logic [IT_W-1:0]           iter_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d    = state_q;
        phase_step = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                phase_step = 1'b1;
                state_d    = ST_ROTATE;
            end
            ST_ROTATE: begin
                if (iter_q == LAST) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                done    = 1'b1;
                state_d = ST_LOAD;
            end
            default: state_d = ST_LOAD;
        endcase
    end

    assign atan_i = PHASE_W'(atan_turns(int'(iter_q), PHASE_W));
    assign dx     = x_q >>> iter_q;
    assign dy     = y_q >>> iter_q;

    // Rotation datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            iter_q <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    x_q    <= x_init;
                    y_q    <= y_init;
                    z_q    <= z_init;
                    iter_q <= '0;
                end
                ST_ROTATE: begin
                    if (z_q[PHASE_W-1]) begin
                        x_q <= x_q + dy;
                        y_q <= y_q - dx;
                        z_q <= z_q + atan_i;
                    end else begin
                        x_q <= x_q - dy;
                        y_q <= y_q + dx;
                        z_q <= z_q - atan_i;
                    end
                    iter_q <= iter_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign x_res = x_q;
    assign y_res = y_q;
    assign z_res = z_q;
    assign state = state_q;
    assign iter  = iter_q;
endmodule

// File: rtl/cordic_nco.sv
module cordic_nco
    import nco_pkg::*;
#(
    parameter int     SEL_W     = 5,
    parameter int     PHASE_W   = 24,
    parameter int     OUT_W     = 10,
    parameter int     ITERS     = 12,
    parameter int     GUARD     = 6,
    parameter longint CLK_HZ    = 56_000_000,
    parameter longint F_BASE_HZ = 100,
    parameter longint STEP_NUM  = 1346,
    parameter longint STEP_DEN  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] freq_sel,
    input  logic             func_sel,
    output logic [OUT_W-1:0] sample_out,
    output logic             sample_valid
);
    localparam int W             = OUT_W + GUARD + 2;
    localparam int IT_W          = $clog2(ITERS + 1);
    localparam int SAMPLE_CYCLES = ITERS + 2;
    localparam longint AMP       = (longint'(1) <<< (OUT_W - 1)) - 1;
    // Start magnitude pre-scaled by 1/K (K about 1.6468), 19899/32768.
    localparam logic signed [W-1:0] X0 = W'(((AMP <<< GUARD) * 19899) / 32768);
    localparam logic signed [W:0]   LIM = (W+1)'(AMP);

    logic [PHASE_W-1:0]        phase;
    logic                      phase_step, done;
    logic signed [W-1:0]       x_init, y_init, x_res, y_res;
    logic signed [PHASE_W-1:0] z_init, z_res;
    cordic_state_e             core_state;
    logic [IT_W-1:0]           core_iter;

    nco_angle_gen #(
        .SEL_W(SEL_W), .PHASE_W(PHASE_W), .CLK_HZ(CLK_HZ),
        .SAMPLE_CYCLES(SAMPLE_CYCLES), .F_BASE_HZ(F_BASE_HZ),
        .STEP_NUM(STEP_NUM), .STEP_DEN(STEP_DEN)
    ) u_angle (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel),
        .step(phase_step), .phase(phase)
    );

    nco_prerotate #(.PHASE_W(PHASE_W), .W(W), .X0(X0)) u_prerot (
        .phase(phase), .x_init(x_init), .y_init(y_init), .z_init(z_init)
    );

    nco_cordic_core #(.W(W), .PHASE_W(PHASE_W), .ITERS(ITERS), .IT_W(IT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .x_init(x_init), .y_init(y_init), .z_init(z_init),
        .phase_step(phase_step), .done(done),
        .x_res(x_res), .y_res(y_res), .z_res(z_res),
        .state(core_state), .iter(core_iter)
    );

    // Round away guard bits, clamp symmetric, flip MSB for offset binary.
    function automatic logic [OUT_W-1:0] to_dac(input logic signed [W-1:0] v);
        logic signed [W:0] r;
        logic signed [W:0] q;
        r = {v[W-1], v} + (W+1)'(1 <<< (GUARD - 1));
        q = r >>> GUARD;
        if (q > LIM)       q = LIM;
        else if (q < -LIM) q = -LIM;
        return {~q[OUT_W-1], q[OUT_W-2:0]};
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_out   <= OUT_W'(1) << (OUT_W - 1);
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= done;
            if (done) sample_out <= to_dac(func_sel ? x_res : y_res);
        end
    end
endmodule

// File: rtl/nco_chk.sv
module nco_chk
    import nco_pkg::*;
#(
    parameter int OUT_W   = 10,
    parameter int PHASE_W = 24,
    parameter int ITERS   = 12,
    parameter int IT_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sample_valid,
    input logic [OUT_W-1:0]          sample_out,
    input cordic_state_e             core_state,
    input logic [IT_W-1:0]           core_iter,
    input logic signed [PHASE_W-1:0] z_res,
    input logic [PHASE_W-1:0]        phase
);
    localparam logic [PHASE_W-1:0] Z_TOL = PHASE_W'(2 * atan_turns(ITERS - 1, PHASE_W));

    logic [PHASE_W-1:0] z_mag;
    assign z_mag = z_res[PHASE_W-1] ? PHASE_W'(-z_res) : PHASE_W'(z_res);

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R2
    strobe_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_valid) |-> $past(core_state == ST_EMIT));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample_out));

    // R4
    phase_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state != ST_LOAD) |=> $stable(phase));

    // R6
    iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == ST_ROTATE) |-> (core_iter < IT_W'(ITERS)));

    // R5
    residual_angle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == ST_EMIT) |-> (z_mag <= Z_TOL));

    // R7
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (sample_out != '0));
endmodule

bind cordic_nco nco_chk #(
    .OUT_W(OUT_W), .PHASE_W(PHASE_W), .ITERS(ITERS), .IT_W(IT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_out(sample_out),
    .core_state(core_state), .core_iter(core_iter), .z_res(z_res), .phase(phase)
);

// File: tb/cordic_nco_tb.sv
`timescale 1ns/1ps
module cordic_nco_tb;
    localparam int     PERIOD_CYC = 14;
    localparam longint FS         = 56_000_000 / 14;
    localparam int     NSAMP      = 260;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] freq_sel = '0;
    logic       func_sel = 1'b0;
    logic [9:0] sample_out;
    logic       sample_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cordic_nco u_dut (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .func_sel(func_sel),
        .sample_out(sample_out), .sample_valid(sample_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3 frequency ladder and step, written from the requirement
    function automatic longint step_for(input int code);
        longint f = 100;
        for (int k = 0; k < code; k++) f = (f * 1346) / 1000;
        return ((f * (longint'(1) << 24)) + FS / 2) / FS;
    endfunction

    function automatic int sel_for(input int k);
        if (k < 60)  return 31;
        if (k < 100) return 17;
        if (k < 130) return 0;
        if (k < 200) return 28;
        return 9;
    endfunction

    function automatic bit func_for(input int k);
        if (k >= 30 && k < 60) return 1'b1;
        if (k >= 100)          return k[0];
        return 1'b0;
    endfunction

    function automatic int ideal(input longint p, input bit cosine);
        real a, s;
        a = 2.0 * 3.14159265358979 * real'(p) / 16777216.0;
        s = cosine ? 511.0 * $cos(a) : 511.0 * $sin(a);
        return $rtoi(s + ((s >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        longint q_phase[$];
        longint acc_m, p;
        bit     func_used;
        int     k, cnt, dec, ex, wraps;
        bit [3:0] quad_seen;
        logic [9:0] prev_out;

        k = 0; wraps = 0; quad_seen = '0;
        freq_sel = 5'(sel_for(0));
        func_sel = func_for(0);
        repeat (4) @(negedge clk);
        // R1 reset state
        check(sample_out == 10'd512, "R1", "sample_out in reset", sample_out, 512);
        check(sample_valid == 1'b0, "R1", "valid in reset", sample_valid, 0);
        rst_n = 1'b1;
        q_phase.push_back(0);
        acc_m     = step_for(sel_for(0));
        func_used = func_for(0);
        prev_out  = 10'd512;
        cnt = 0;
        while (k < NSAMP) begin
            @(negedge clk);
            cnt++;
            // R2 strobe cadence
            check(sample_valid == ((cnt % PERIOD_CYC) == 0), "R2", "strobe timing",
                  sample_valid, ((cnt % PERIOD_CYC) == 0));
            if (sample_valid) begin
                p   = q_phase.pop_front();
                quad_seen[p[23:22]] = 1'b1;
                ex  = ideal(p, func_used);
                dec = int'(sample_out) - 512;
                check(dec - ex <= 3 && ex - dec <= 3,
                      (k >= 100) ? "R9 R6" : "R6 (phase per R3 R4 R5)",
                      "sample value", dec, ex);
                // R7 offset binary: clamped value never yields code 0
                check(sample_out != 10'd0, "R7", "offset code", sample_out, 1);
                if (ex > 3) check(sample_out[9] == 1'b1, "R7", "msb for positive", sample_out[9], 1);
                if (ex < -3) check(sample_out[9] == 1'b0, "R7", "msb for negative", sample_out[9], 0);
                prev_out = sample_out;
                k++;
                freq_sel  = 5'(sel_for(k));
                func_sel  = func_for(k);
                func_used = func_for(k);
                q_phase.push_back(acc_m);
                if (acc_m + step_for(sel_for(k)) >= (longint'(1) << 24)) wraps++;
                acc_m = (acc_m + step_for(sel_for(k))) % (longint'(1) << 24);
            end else begin
                if (cnt < PERIOD_CYC)
                    check(sample_out == 10'd512, "R1", "idle before first strobe", sample_out, 512);
                check(sample_out == prev_out, "R8", "hold between strobes", sample_out, prev_out);
            end
        end
        check(wraps > 0, "R4", "phase wrap exercised", wraps, 1);
        check(quad_seen == 4'hF, "R5", "all quadrants exercised", quad_seen, 15);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule